// File: doc/BRIEF.md
# Three-Source Interrupt Controller for a 4-bit Core

This block sits beside the execute stage of a small 4-bit core. It collects interrupt requests from three sources: an external pin, and two timers that deliver single-cycle request pulses. Each source has a request flag. A 4-bit enable register is loaded from the accumulator and read back onto a 4-bit bus. A global enable flag is set by the enable-interrupts instruction.

When the global flag, a source's enable bit and that source's request flag are all 1, the controller counts a short or long latency. The length depends on the instruction running at that moment. It then issues a one-cycle take strobe with a 2-bit vector code. Taking an interrupt drops the global flag and the serviced request.

Polling instructions can test a request flag with a skip result. The test only works for a source whose enable bit is clear, and a successful test consumes the flag. The pin input is qualified by a run-length filter before it can raise its request.

Top module: `irq_ctl4`

## Requirements
- R1: A write strobe loads all four enable bits from the write data, including bit 1, which has no function but keeps its value. The read bus always shows the register.
- R2: The enable register is 0000 after reset. A power-down strobe clears it to 0000, and the clear wins over a write in the same cycle.
- R3: A take strobe occurs only for a source whose global flag, enable bit and request flag are all 1. Enable bit map: bit 0 = pin source, bit 2 = timer 1, bit 3 = timer 2.
- R4: Suppose the three conditions first hold in cycle n and stay true, and the short-instruction input is 1 in cycle n. Then the take strobe is high in cycle n+2.
- R5: Under the same conditions with the short-instruction input 0 in cycle n, the take strobe is high in cycle n+3.
- R6: If several sources qualify, the pin source wins over timer 1, which wins over timer 2. The vector code is 0 for the pin, 1 for timer 1 and 2 for timer 2.
- R7: A take clears the global flag and the serviced request flag on the next edge. No further take occurs until the enable instruction runs again.
- R8: A poll of a source reports a skip only if its enable bit is 0 and its flag is 1. With the enable bit 1 the poll reports no skip and leaves the flag unchanged.
- R9: A poll that reports a skip clears that source's request flag.
- R10: The pin request flag is set only after the pin has been high for 4 consecutive clocks. It is set once for each high period.
- R11: A request pulse arriving in the same cycle as a clear of that flag leaves the flag set.
- R12: The enable-interrupts input sets the global flag on the next edge unless a take occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle per machine cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pdown_i | input | 1 | Power-down entry strobe; clears the enable register |
| en_wr_i | input | 1 | Transfer-from-accumulator strobe for the enable register |
| en_wdata_i | input | 4 | Accumulator value to load |
| en_rdata_o | output | 4 | Enable register contents |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| insn_short_i | input | 1 | 1 while the running instruction is a one-cycle instruction |
| ext_pin_i | input | 1 | External interrupt pin level |
| tmr1_req_i | input | 1 | Timer 1 request pulse |
| tmr2_req_i | input | 1 | Timer 2 request pulse |
| poll_i | input | 3 | Skip-test strobes: bit 0 pin, bit 1 timer 1, bit 2 timer 2 |
| skip_o | output | 3 | Skip results, same bit order as poll_i |
| take_o | output | 1 | Interrupt-taken strobe |
| vec_o | output | 2 | Vector code of the serviced source, valid with take_o |

## Verification
A corrupted enable bit appears on the read bus in the cycle after the write. It also shows up as a wrong skip or take decision as soon as that source is polled or pending.

A request flag stuck high or cleared by mistake shows up at the next poll of that source. If the source is enabled, it shows up instead as a take that appears or goes missing two or three cycles later.

An error in the latency counter or the priority order is visible only at the take strobe and vector code. The bench compares these against its cycle-counting model on every clock, so such an error is reported in the exact cycle where the strobe should or should not appear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned EN_W  = 4;
  localparam int unsigned VEC_W = 2;
  // enable-register bit that gates each source (pin, timer 1, timer 2)
  localparam int unsigned SRC_EN_BIT [NSRC] = '{0, 2, 3};

  typedef enum logic [VEC_W-1:0] {
    VEC_PIN = 2'd0,
    VEC_TM1 = 2'd1,
    VEC_TM2 = 2'd2
  } irq_vec_e;
endpackage

// File: rtl/irq_pin_filter.sv
module irq_pin_filter #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic set_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q, run_d;

  // one pulse when the high run reaches RUN_LEN samples
  assign set_o = pin_i && (run_q == CW'(RUN_LEN - 1));

  always_comb begin
    run_d = run_q;
    if (!pin_i)                    run_d = '0;
    else if (run_q != CW'(RUN_LEN)) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar k = 0; k < N; k++) begin : g_flag
    // a new request outranks any clear in the same cycle
    always_comb begin
      flag_d[k] = flag_q[k];
      if (set_i[k])      flag_d[k] = 1'b1;
      else if (clr_i[k]) flag_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned N         = 3,
  parameter int unsigned VW        = 2,
  parameter int unsigned SHORT_LAT = 2,
  parameter int unsigned LONG_LAT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand_i,
  input  logic          short_i,
  output logic          take_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  sel_o
);
  localparam int unsigned CW = $clog2(LONG_LAT + 1);

  logic          any;
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign any = |cand_i;

  // fixed priority: lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    vec_o = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (cand_i[k] && !found) begin
        sel_o[k] = 1'b1;
        vec_o    = VW'(k);
        found    = 1'b1;
      end
    end
  end

  assign take_o = armed_q && (cnt_q == '0) && any;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!any || take_o) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (!armed_q) begin
      armed_d = 1'b1;
      cnt_d   = short_i ? CW'(SHORT_LAT - 1) : CW'(LONG_LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_ctl4.sv
module irq_ctl4
  import irq_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 4,
  parameter int unsigned SHORT_LAT = 2,
  parameter int unsigned LONG_LAT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdown_i,
  input  logic             en_wr_i,
  input  logic [EN_W-1:0]  en_wdata_i,
  output logic [EN_W-1:0]  en_rdata_o,
  input  logic             ei_i,
  input  logic             insn_short_i,
  input  logic             ext_pin_i,
  input  logic             tmr1_req_i,
  input  logic             tmr2_req_i,
  input  logic [NSRC-1:0]  poll_i,
  output logic [NSRC-1:0]  skip_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [EN_W-1:0] en_q, en_d;
  logic            gie_q, gie_d;
  logic [NSRC-1:0] en_src, flag_q, set_v, clr_v, cand, sel;
  logic            pin_set;

  for (genvar k = 0; k < int'(NSRC); k++) begin : g_en_map
    assign en_src[k] = en_q[SRC_EN_BIT[k]];
  end

  irq_pin_filter #(.RUN_LEN(FILT_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_i (ext_pin_i),
    .set_o (pin_set)
  );

  assign set_v  = {tmr2_req_i, tmr1_req_i, pin_set};
  assign skip_o = poll_i & ~en_src & flag_q;
  assign clr_v  = skip_o | (sel & {NSRC{take_o}});
  assign cand   = {NSRC{gie_q}} & en_src & flag_q;

  irq_req_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_q)
  );

  irq_entry_seq #(
    .N(NSRC), .VW(VEC_W), .SHORT_LAT(SHORT_LAT), .LONG_LAT(LONG_LAT)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cand_i  (cand),
    .short_i (insn_short_i),
    .take_o  (take_o),
    .vec_o   (vec_o),
    .sel_o   (sel)
  );

  always_comb begin
    en_d = en_q;
    if (pdown_i)      en_d = '0;
    else if (en_wr_i) en_d = en_wdata_i;
    gie_d = gie_q;
    if (take_o)    gie_d = 1'b0;
    else if (ei_i) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      gie_q <= gie_d;
    end
  end

  assign en_rdata_o = en_q;
endmodule

// File: rtl/irq_ctl4_checker.sv
module irq_ctl4_checker
  import irq_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EN_W-1:0]  en_q,
  input logic             gie_q,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  set_v,
  input logic [NSRC-1:0]  poll_i,
  input logic [NSRC-1:0]  skip_o,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ei_i,
  input logic             pdown_i,
  input logic             en_wr_i,
  input logic [EN_W-1:0]  en_wdata_i,
  input logic             ext_pin_i
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  logic [CW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_q <= '0;
    else if (!ext_pin_i)         hi_q <= '0;
    else if (hi_q != CW'(FILT_LEN)) hi_q <= hi_q + 1'b1;
  end

  logic [NSRC-1:0] en_src;
  for (genvar k = 0; k < int'(NSRC); k++) begin : g_map
    assign en_src[k] = en_q[SRC_EN_BIT[k]];
  end

  p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i && !pdown_i |=> en_q == $past(en_wdata_i));
  p_pdown_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_i |=> en_q == '0);
  p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> gie_q && en_src[vec_o] && flag_q[vec_o]);
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !set_v[vec_o] |=> !gie_q && !flag_q[$past(vec_o)]);
  p_skip_disabled_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_o & en_src) == '0);
  p_pin_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_v[0] |-> ext_pin_i && hi_q == CW'(FILT_LEN - 1));
  p_ei_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ei_i && !take_o |=> gie_q);

  for (genvar k = 0; k < int'(NSRC); k++) begin : g_src
    p_poll_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o[k] && !set_v[k] |=> !flag_q[k]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[k] |=> flag_q[k]);
  end
endmodule

bind irq_ctl4 irq_ctl4_checker #(.FILT_LEN(FILT_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .en_q       (en_q),
  .gie_q      (gie_q),
  .flag_q     (flag_q),
  .set_v      (set_v),
  .poll_i     (poll_i),
  .skip_o     (skip_o),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .ei_i       (ei_i),
  .pdown_i    (pdown_i),
  .en_wr_i    (en_wr_i),
  .en_wdata_i (en_wdata_i),
  .ext_pin_i  (ext_pin_i)
);

// File: tb/irq_ctl4_test.sv
module irq_ctl4_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdown = 1'b0, wr = 1'b0, ei = 1'b0, short_i = 1'b1;
  logic [3:0] wdata = 4'h0;
  logic       pin = 1'b0, t1 = 1'b0, t2 = 1'b0;
  logic [2:0] poll = 3'b000;
  logic [3:0] rdata;
  logic [2:0] skip;
  logic       take;
  logic [1:0] vec;

  always #2.5 clk = ~clk;

  irq_ctl4 uut (
    .clk(clk), .rst_n(rst_n), .pdown_i(pdown), .en_wr_i(wr), .en_wdata_i(wdata),
    .en_rdata_o(rdata), .ei_i(ei), .insn_short_i(short_i), .ext_pin_i(pin),
    .tmr1_req_i(t1), .tmr2_req_i(t2), .poll_i(poll), .skip_o(skip),
    .take_o(take), .vec_o(vec)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur = "R2";

  // behavioural reference model
  int unsigned m_en, m_gie, m_run, m_cyc;
  int          m_due;
  int unsigned m_flag [3];
  bit          e_take;
  int unsigned e_vec;
  bit [2:0]    e_skip;

  function automatic bit en_of(int s);
    case (s)
      0: return m_en[0];
      1: return m_en[2];
      default: return m_en[3];
    endcase
  endfunction

  function automatic void evaluate();
    bit any = 1'b0;
    e_vec = 0;
    for (int s = 0; s < 3; s++) begin
      if (m_gie == 1 && en_of(s) && m_flag[s] == 1 && !any) begin
        any = 1'b1; e_vec = s;
      end
      e_skip[s] = poll[s] && !en_of(s) && m_flag[s] == 1;
    end
    e_take = any && (m_due == int'(m_cyc));
    if (!any) m_due = -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_gie = 0; m_run = 0; m_cyc = 0; m_due = -1;
      for (int s = 0; s < 3; s++) m_flag[s] = 0;
    end else begin
      bit pset, anyp;
      bit sets [3];
      evaluate();
      anyp = 1'b0;
      for (int s = 0; s < 3; s++)
        if (m_gie == 1 && en_of(s) && m_flag[s] == 1) anyp = 1'b1;
      pset = pin && (m_run == 3);
      m_run = pin ? m_run + 1 : 0;
      sets[0] = pset; sets[1] = t1; sets[2] = t2;
      for (int s = 0; s < 3; s++) begin
        if (sets[s]) m_flag[s] = 1;
        else if (e_skip[s] || (e_take && e_vec == s)) m_flag[s] = 0;
      end
      if (e_take) m_gie = 0; else if (ei) m_gie = 1;
      if (pdown) m_en = 0; else if (wr) m_en = wdata;
      if (e_take || !anyp) m_due = -1;
      else if (m_due < 0) m_due = int'(m_cyc) + (short_i ? 2 : 3);
      m_cyc++;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      evaluate();
      chk(rdata == 4'(m_en), "enable readback R1", rdata, m_en);
      chk(take == e_take, "take strobe R3", take, e_take);
      if (e_take) chk(vec == 2'(e_vec), "vector R6", vec, e_vec);
      chk(skip == e_skip, "skip bits R8", skip, e_skip);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wen(logic [3:0] v);
    wr = 1'b1; wdata = v; step(); wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    cur = "R2";
    step(3); rst_n = 1'b1; step(5);
    cur = "R1";
    wen(4'b0010); step(2); wen(4'b1111); step(); wen(4'b0000); step();
    cur = "R10";
    pin = 1'b1; step(3); pin = 1'b0; step(2);
    poll = 3'b001; step(); poll = 3'b000; step();
    pin = 1'b1; step(6); pin = 1'b0; step();
    cur = "R9";
    poll = 3'b001; step(); poll = 3'b001; step(); poll = 3'b000; step();
    cur = "R11";
    t1 = 1'b1; step(); t1 = 1'b0; step();
    poll = 3'b010; t1 = 1'b1; step(); t1 = 1'b0; step(); poll = 3'b000; step();
    cur = "R8";
    wen(4'b0100); t1 = 1'b1; step(); t1 = 1'b0;
    poll = 3'b010; step(); poll = 3'b000; step(2);
    cur = "R4";
    short_i = 1'b1; ei = 1'b1; step(); ei = 1'b0; step(6);
    cur = "R7";
    t1 = 1'b1; step(); t1 = 1'b0; step(6);
    cur = "R5";
    short_i = 1'b0; ei = 1'b1; step(); ei = 1'b0; step(6); short_i = 1'b1;
    cur = "R6";
    wen(4'b1101); t1 = 1'b1; t2 = 1'b1; step(); t1 = 1'b0; t2 = 1'b0;
    pin = 1'b1; step(5); pin = 1'b0; step();
    ei = 1'b1; step(); ei = 1'b0; step(5);
    ei = 1'b1; step(); ei = 1'b0; step(5);
    ei = 1'b1; step(); ei = 1'b0; step(5);
    cur = "R3";
    wen(4'b0000); t2 = 1'b1; step(); t2 = 1'b0;
    ei = 1'b1; step(); ei = 1'b0; step(5);
    poll = 3'b100; step(); poll = 3'b000; step();
    cur = "R12";
    wen(4'b1000); t2 = 1'b1; step(); t2 = 1'b0; step(5);
    cur = "R2";
    wen(4'b1111); step();
    pdown = 1'b1; wr = 1'b1; wdata = 4'b1010; step();
    pdown = 1'b0; wr = 1'b0; step(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule